// File: doc/BRIEF.md
# Eight-Channel Timer Compare and Capture Unit

This block is a timer peripheral with eight channels that share one free-running 16-bit counter. Each channel works in one of two modes. In capture mode, a rising edge on its pin stores the counter value. In compare mode, the channel acts on its pin when the counter reaches the channel's stored value. Software runs the unit through a small byte-addressed register bus. A write-only force register lets software fire any compare channel's pin action on demand. Channel 7 can take over a chosen set of pins and drive fixed levels onto them. A single interrupt line reports the channel flags that software has enabled.

A two-state machine controls the counter.
- In HALT the counter holds its value.
- In RUN the counter advances by one every cycle and wraps from 0xFFFF to 0x0000.
- The transition *start* (HALT to RUN) happens on a write to address 0x00 with bit 0 set.
- The transition *stop* (RUN to HALT) happens on a write to address 0x00 with bit 0 clear.

Compare matches are evaluated only on cycles where the counter advances, that is, in RUN.

Register map. Bus writes take effect at the clock edge that samples `bus_we`. Reads are combinational.
- 0x00: run control.
- 0x01: mode, one bit per channel; 1 selects compare.
- 0x02: force; reads back as zero.
- 0x03: channel-7 override mask.
- 0x04: channel-7 override levels.
- 0x05: action codes for channels 0 to 3. Channel n uses bits [2n+1:2n].
- 0x06: action codes for channels 4 to 7. Channel n uses bits [2(n-4)+1:2(n-4)].
- 0x07: flags; write 1 to clear.
- 0x08: interrupt enable.
- 0x0A: counter high byte (read only).
- 0x0B: counter low byte (read only).
- 0x10+2n: channel n value, high byte.
- 0x11+2n: channel n value, low byte.

Top module: `tcmp_unit`

## Requirements
- R1: After reset the counter, mode, flags, pin outputs, pin enables and `irq` are all zero, and the state is HALT.
- R2: The counter holds in HALT. In RUN it increments once per clock and wraps modulo 65536. It reads back high byte at 0x0A and low byte at 0x0B.
- R3: When a compare-mode channel's value equals the counter on a RUN cycle, its action is applied at that edge and its flag (bit n of 0x07) is set. Action codes: 00 leaves the pin alone, 01 toggles it, 10 drives 0, 11 drives 1.
- R4: Writing 1 to bit n of 0x02 applies channel n's action at that edge if the channel is in compare mode, and never sets its flag. A force on a capture-mode channel has no effect. Reading 0x02 returns 0.
- R5: When a force and a real match hit the same channel at the same edge, the action is applied exactly once and the flag stays clear.
- R6: When channel 7 fires (by match or force), every pin whose bit is set in 0x03 takes the matching bit of 0x04. This overrides that pin's own action at the same edge.
- R7: A rising edge on `pin_in[n]` of a capture-mode channel copies the counter into channel n's value and sets flag n. Compare-mode channels ignore `pin_in`.
- R8: Writing 1 to a flag bit clears only that bit. `irq` is high exactly when some flag bit and its enable bit in 0x08 are both 1.
- R9: `pin_oe[n]` is 1 when channel n is in compare mode and either its action code is not 00, or its mask bit is set while channel 7 is in compare mode. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pin_in | input | 8 | Timer pin inputs used by capture channels |
| pin_out | output | 8 | Timer pin output levels |
| pin_oe | output | 8 | Timer pin output enables |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with its default parameters: eight channels, a 16-bit counter and a 5-bit address. With these values a full counter lap takes 65536 cycles, which is short enough that the bench runs one complete lap and checks that the counter lands back on its starting value. The eight-bit force, mask and action registers are small enough for random patterns to cover many mixes of modes, codes and channel-7 overrides. Directed runs then line a force up with a real match at the exact cycle on which both occur.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

    typedef enum logic {
        T_HALT = 1'b0,
        T_RUN  = 1'b1
    } tstate_e;

    localparam logic [7:0] A_CTRL   = 8'h00;
    localparam logic [7:0] A_MODE   = 8'h01;
    localparam logic [7:0] A_FORCE  = 8'h02;
    localparam logic [7:0] A_OMASK  = 8'h03;
    localparam logic [7:0] A_ODATA  = 8'h04;
    localparam logic [7:0] A_ACTLO  = 8'h05;
    localparam logic [7:0] A_ACTHI  = 8'h06;
    localparam logic [7:0] A_FLAG   = 8'h07;
    localparam logic [7:0] A_IEN    = 8'h08;
    localparam logic [7:0] A_CNTH   = 8'h0A;
    localparam logic [7:0] A_CNTL   = 8'h0B;
    localparam int         A_CHBASE = 16;

    // Pin level produced by one channel action code.
    function automatic logic act_apply(input logic [1:0] code, input logic cur);
        logic r;
        unique case (code)
            2'b00: r = cur;
            2'b01: r = ~cur;
            2'b10: r = 1'b0;
            2'b11: r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tcmp_counter.sv
module tcmp_counter
    import tcmp_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_req,
    input  logic          stop_req,
    output logic          running,
    output logic [CW-1:0] cnt
);

    tstate_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_HALT: if (start_req) state_d = T_RUN;
            T_RUN:  if (stop_req)  state_d = T_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= T_HALT;
        else        state_q <= state_d;
    end

    // outputs of the state machine
    always_comb begin
        running = 1'b0;
        unique case (state_q)
            T_HALT: running = 1'b0;
            T_RUN:  running = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (running) cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/tcmp_chan.sv
module tcmp_chan #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmp_mode,
    input  logic          tick,
    input  logic [CW-1:0] cnt,
    input  logic          cap_edge,
    input  logic          force_hit,
    input  logic          wr_hi,
    input  logic          wr_lo,
    input  logic [7:0]    wdata,
    output logic [CW-1:0] val,
    output logic          fire,
    output logic          flag_set
);

    logic match;

    assign match    = tick & cmp_mode & (val == cnt);
    assign fire     = cmp_mode & (match | force_hit);
    // a force on the same edge suppresses the flag of a real match
    assign flag_set = (match & ~force_hit) | (cap_edge & ~cmp_mode);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val <= '0;
        end else if (cap_edge && !cmp_mode) begin
            val <= cnt;
        end else begin
            if (wr_hi) val[CW-1:8] <= (CW-8)'(wdata);
            if (wr_lo) val[7:0]    <= wdata;
        end
    end

endmodule

// File: rtl/tcmp_pins.sv
module tcmp_pins
    import tcmp_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   fire,
    input  logic [NCH-1:0]   mode,
    input  logic [2*NCH-1:0] act,
    input  logic [NCH-1:0]   ovr_mask,
    input  logic [NCH-1:0]   ovr_data,
    output logic [NCH-1:0]   pin_out,
    output logic [NCH-1:0]   pin_oe
);

    localparam int TOP = NCH - 1;

    logic [NCH-1:0] nxt;

    for (genvar i = 0; i < NCH; i++) begin : g_bit
        logic own;
        logic act_on;
        assign own    = fire[i] ? act_apply(act[2*i +: 2], pin_out[i]) : pin_out[i];
        assign nxt[i] = (fire[TOP] && ovr_mask[i]) ? ovr_data[i] : own;
        assign act_on = (act[2*i +: 2] != 2'b00);
        assign pin_oe[i] = mode[i] & (act_on | (ovr_mask[i] & mode[TOP]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_out <= '0;
        else        pin_out <= nxt;
    end

endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit
    import tcmp_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 16,
    parameter int AW  = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [7:0]     bus_wdata,
    output logic [7:0]     bus_rdata,
    input  logic [NCH-1:0] pin_in,
    output logic [NCH-1:0] pin_out,
    output logic [NCH-1:0] pin_oe,
    output logic           irq
);

    localparam int HALF = NCH / 2;
    localparam int ACTW = 2 * NCH;

    logic [NCH-1:0]  mode_q, ovr_mask_q, ovr_data_q, flag_q, ien_q, pin_q;
    logic [ACTW-1:0] act_q;
    logic [NCH-1:0]  force_v, cap_edge, fire, flag_set, flag_clr;
    logic [CW-1:0]   cnt;
    logic            running;
    logic [CW-1:0]   ch_val [NCH];

    function automatic logic wr_at(input logic [7:0] a);
        return bus_we && (bus_addr == AW'(a));
    endfunction

    tcmp_counter #(.CW(CW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (wr_at(A_CTRL) &&  bus_wdata[0]),
        .stop_req  (wr_at(A_CTRL) && !bus_wdata[0]),
        .running   (running),
        .cnt       (cnt)
    );

    assign force_v  = wr_at(A_FORCE) ? bus_wdata[NCH-1:0] : '0;
    assign flag_clr = wr_at(A_FLAG)  ? bus_wdata[NCH-1:0] : '0;
    assign cap_edge = pin_in & ~pin_q & ~mode_q;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tcmp_chan #(.CW(CW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmp_mode  (mode_q[i]),
            .tick      (running),
            .cnt       (cnt),
            .cap_edge  (cap_edge[i]),
            .force_hit (force_v[i]),
            .wr_hi     (bus_we && (bus_addr == AW'(A_CHBASE + 2*i))),
            .wr_lo     (bus_we && (bus_addr == AW'(A_CHBASE + 2*i + 1))),
            .wdata     (bus_wdata),
            .val       (ch_val[i]),
            .fire      (fire[i]),
            .flag_set  (flag_set[i])
        );
    end

    tcmp_pins #(.NCH(NCH)) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .mode     (mode_q),
        .act      (act_q),
        .ovr_mask (ovr_mask_q),
        .ovr_data (ovr_data_q),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= '0;
            ovr_mask_q <= '0;
            ovr_data_q <= '0;
            act_q      <= '0;
            ien_q      <= '0;
            flag_q     <= '0;
            pin_q      <= '0;
        end else begin
            pin_q  <= pin_in;
            flag_q <= (flag_q & ~flag_clr) | flag_set;
            if (wr_at(A_MODE))  mode_q     <= bus_wdata[NCH-1:0];
            if (wr_at(A_OMASK)) ovr_mask_q <= bus_wdata[NCH-1:0];
            if (wr_at(A_ODATA)) ovr_data_q <= bus_wdata[NCH-1:0];
            if (wr_at(A_IEN))   ien_q      <= bus_wdata[NCH-1:0];
            if (wr_at(A_ACTLO)) act_q[ACTW/2-1:0]    <= bus_wdata[2*HALF-1:0];
            if (wr_at(A_ACTHI)) act_q[ACTW-1:ACTW/2] <= bus_wdata[2*HALF-1:0];
        end
    end

    assign irq = |(flag_q & ien_q);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(A_CTRL):  bus_rdata = {7'd0, running};
            AW'(A_MODE):  bus_rdata = mode_q;
            AW'(A_OMASK): bus_rdata = ovr_mask_q;
            AW'(A_ODATA): bus_rdata = ovr_data_q;
            AW'(A_ACTLO): bus_rdata = act_q[ACTW/2-1:0];
            AW'(A_ACTHI): bus_rdata = act_q[ACTW-1:ACTW/2];
            AW'(A_FLAG):  bus_rdata = flag_q;
            AW'(A_IEN):   bus_rdata = ien_q;
            AW'(A_CNTH):  bus_rdata = cnt[CW-1:CW-8];
            AW'(A_CNTL):  bus_rdata = cnt[7:0];
            default:      bus_rdata = '0;
        endcase
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == AW'(A_CHBASE + 2*i))     bus_rdata = ch_val[i][CW-1:CW-8];
            if (bus_addr == AW'(A_CHBASE + 2*i + 1)) bus_rdata = ch_val[i][7:0];
        end
    end

endmodule

// File: rtl/tcmp_checker.sv
module tcmp_checker
    import tcmp_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 16,
    parameter int AW  = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_we,
    input logic [AW-1:0]  bus_addr,
    input logic [7:0]     bus_wdata,
    input logic [7:0]     bus_rdata,
    input logic [NCH-1:0] pin_oe,
    input logic           irq,
    input logic [NCH-1:0] flags,
    input logic [NCH-1:0] mode,
    input logic [CW-1:0]  cnt,
    input logic           running
);

    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (cnt == $past(cnt)));

    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> (cnt == $past(cnt) + 1'b1));

    // a compare-mode flag can only rise after a running cycle
    assert_flag_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags & ~$past(flags) & $past(mode))) |-> $past(running));

    assert_force_no_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(A_FORCE))
            |=> ((flags & $past(bus_wdata[NCH-1:0] & mode & ~flags)) == '0));

    assert_force_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(A_FORCE)) |-> (bus_rdata == 8'd0));

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (flags != '0));

    assert_oe_capture_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != {NCH{1'b1}}) |-> ((pin_oe & ~mode) == '0));

endmodule

bind tcmp_unit tcmp_checker #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .flags     (flag_q),
    .mode      (mode_q),
    .cnt       (cnt),
    .running   (running)
);

// File: tb/sim_tcmp_unit.sv
`timescale 1ns/1ps
module sim_tcmp_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe;
    logic       irq;

    int unsigned n_run = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    tcmp_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_cnt(output logic [15:0] c);
        logic [7:0] h, l;
        rd(5'h0A, h); rd(5'h0B, l);
        c = {h, l};
    endtask

    function automatic logic [7:0] pin_model(input logic [7:0] base, input logic [7:0] fire,
        input logic [15:0] act, input logic [7:0] mask, input logic [7:0] data);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            r[i] = base[i];
            if (fire[i]) begin
                case (act[2*i +: 2])
                    2'b01: r[i] = ~base[i];
                    2'b10: r[i] = 1'b0;
                    2'b11: r[i] = 1'b1;
                    default: r[i] = base[i];
                endcase
            end
            if (fire[7] && mask[i]) r[i] = data[i];
        end
        return r;
    endfunction

    function automatic logic [7:0] oe_model(input logic [7:0] mode, input logic [15:0] act,
        input logic [7:0] mask);
        logic [7:0] r;
        for (int i = 0; i < 8; i++)
            r[i] = mode[i] & ((act[2*i +: 2] != 2'b00) | (mask[i] & mode[7]));
        return r;
    endfunction

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        logic [7:0] d, base, m, f, mk, dt;
        logic [15:0] c, c2, act;
        int unsigned w, seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_cnt(c); chk("R1 counter", c, 0);
        rd(5'h01, d); chk("R1 mode", d, 0);
        rd(5'h07, d); chk("R1 flags", d, 0);
        chk("R1 pin_out", pin_out, 0);
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 irq", irq, 0);
        rd(5'h00, d); chk("R1 halted", d, 0);

        // R2 run for random lengths, then a full lap
        for (int k = 0; k < 5; k++) begin
            rd_cnt(c);
            w = $urandom_range(0, 40);
            wr(5'h00, 8'h01);
            repeat (w) @(negedge clk);
            wr(5'h00, 8'h00);
            rd_cnt(c2); chk("R2 count advance", c2, 16'(c + 1 + w));
            repeat (3) @(negedge clk);
            rd_cnt(c); chk("R2 halt holds", c, c2);
        end
        rd_cnt(c);
        wr(5'h00, 8'h01);
        repeat (65535) @(negedge clk);
        wr(5'h00, 8'h00);
        rd_cnt(c2); chk("R2 wrap full lap", c2, c);

        // R7 captures with random modes and edges
        for (int k = 0; k < 8; k++) begin
            wr(5'h07, 8'hFF);
            m = 8'($urandom());
            f = 8'($urandom()) | 8'h01;
            wr(5'h01, m);
            wr(5'h05, 8'h00); wr(5'h06, 8'h00);
            rd_cnt(c);
            pin_in = f;
            @(negedge clk);
            pin_in = '0;
            @(negedge clk);
            rd(5'h07, d); chk("R7 capture flags", d, f & ~m);
            for (int i = 0; i < 8; i++) begin
                if (f[i] && !m[i]) begin
                    rd(5'(16 + 2*i), d); rd(5'(17 + 2*i), base);
                    chk("R7 captured value", {d, base}, c);
                end
            end
        end

        // R4 R6 R9 random forced actions with timer halted
        wr(5'h07, 8'hFF);
        for (int k = 0; k < 24; k++) begin
            m = 8'($urandom()); act = 16'($urandom());
            mk = 8'($urandom()); dt = 8'($urandom()); f = 8'($urandom());
            wr(5'h01, m); wr(5'h05, act[7:0]); wr(5'h06, act[15:8]);
            wr(5'h03, mk); wr(5'h04, dt);
            chk("R9 output enables", pin_oe, oe_model(m, act, mk));
            base = pin_out;
            wr(5'h02, f);
            chk("R4 R6 forced pins", pin_out, pin_model(base, f & m, act, mk, dt));
            rd(5'h07, d); chk("R4 force leaves flags", d, 0);
            rd(5'h02, d); chk("R4 force reads zero", d, 0);
        end

        // R6 directed: ch7 forced, ch3 set, mask forces pin3 low
        wr(5'h01, 8'h88); wr(5'h05, 8'hC0); wr(5'h06, 8'h00);
        wr(5'h03, 8'h08); wr(5'h04, 8'h00);
        base = pin_out;
        wr(5'h02, 8'h88);
        chk("R6 override beats own set", pin_out[3], 0);

        // R3 directed compare on channel 2 (toggle)
        wr(5'h03, 8'h00);
        wr(5'h01, 8'h04); wr(5'h05, 8'h10); wr(5'h07, 8'hFF);
        rd_cnt(c); c2 = c + 2;
        wr(5'h14, c2[15:8]); wr(5'h15, c2[7:0]);
        base = pin_out;
        wr(5'h00, 8'h01);
        repeat (2) @(negedge clk);
        chk("R3 before match pin", pin_out, base);
        rd(5'h07, d); chk("R3 before match flag", d, 0);
        @(negedge clk);
        chk("R3 match toggles pin2", pin_out, base ^ 8'h04);
        rd(5'h07, d); chk("R3 match sets flag", d, 8'h04);
        wr(5'h00, 8'h00);

        // R8 interrupt enable and write-1-to-clear
        chk("R8 irq off when disabled", irq, 0);
        wr(5'h08, 8'h04);
        chk("R8 irq on", irq, 1);
        wr(5'h07, 8'h01);
        rd(5'h07, d); chk("R8 other bit kept", d, 8'h04);
        wr(5'h07, 8'h04);
        chk("R8 irq after clear", irq, 0);

        // R5 force lands on the same edge as a real match on channel 5
        wr(5'h01, 8'h20); wr(5'h06, 8'h04); wr(5'h07, 8'hFF);
        rd_cnt(c); c2 = c + 2;
        wr(5'h1A, c2[15:8]); wr(5'h1B, c2[7:0]);
        base = pin_out;
        wr(5'h00, 8'h01);
        repeat (2) @(negedge clk);
        wr(5'h02, 8'h20);
        chk("R5 single toggle", pin_out, base ^ 8'h20);
        rd(5'h07, d); chk("R5 no flag", d, 0);
        wr(5'h00, 8'h00);

        // R7 compare-mode channel ignores its pin
        wr(5'h07, 8'hFF);
        pin_in = 8'h20;
        @(negedge clk);
        pin_in = '0;
        @(negedge clk);
        rd(5'h07, d); chk("R7 compare ignores pin", d, 0);

        report();
    end

endmodule